// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Reader

This block is a hardware master for a three-wire serial EEPROM. A single request carries a word address. The block raises chip select and sends a four-bit lead-in: a dummy zero, a start bit and the read opcode. It then sends the six-bit address and clocks sixteen data bits back from the memory. It delivers the word with its two bytes exchanged, together with a one-cycle completion strobe.

The serial clock comes from the system clock. Each half-period of the serial clock lasts a parameterised number of system cycles. While a read is in flight the block reports itself busy and ignores further requests. A request held asserted across the completion strobe starts the next read at once, so reads can run back to back without a gap cycle.

Top module: `mw_eeprom_reader`

## Requirements
- R1: When a read is accepted, chip select goes high while the serial clock is low, and both stay that way for one half-period before the first rising clock edge.
- R2: The first four bits seen on the data output at rising clock edges are 0, 1, 1, 0, in that order.
- R3: The next six bits on the data output are the word address, bits 5 down to 0 of the request address, most significant first. Request address bits above bit 5 have no effect on the frame or on the result.
- R4: The data output changes only while the serial clock is low, and it holds steady through every high phase.
- R5: After the ten outgoing bits, sixteen incoming bits are taken from the data input, most significant first, each sampled in the last system cycle of a clock-high phase. A frame has exactly 26 rising clock edges.
- R6: The serial clock is high only while chip select is high.
- R7: After the last incoming bit, the clock stays low with chip select still high for one half-period. Then chip select, the clock and the data output all drop to 0 and stay there while idle; all three are also 0 after reset.
- R8: At completion, the word output carries the received byte in bits 15..8 as its bits 7..0, and the received bits 7..0 as its bits 15..8. The done strobe is high for exactly one cycle, and the word output holds its value until the next done strobe. Both are 0 after reset.
- R9: A request is accepted only while the block is idle. Busy is high from the cycle after acceptance up to the cycle of the done strobe, in which it is low. A request presented while busy is ignored. A request present in the done cycle is accepted.
- R10: Every clock-high and clock-low phase lasts HALF_PER system cycles (HALF_PER at least 1). A whole read takes 54 × HALF_PER cycles from acceptance to the done strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request, taken when idle |
| req_addr | input | REQ_ADDR_W | Request address; only bits 5..0 are used |
| busy | output | 1 | A read is in flight |
| done | output | 1 | One-cycle completion strobe |
| rd_word | output | 16 | Byte-swapped word from the last read |
| mw_cs | output | 1 | Chip select to the memory |
| mw_sk | output | 1 | Serial clock to the memory |
| mw_do | output | 1 | Serial data to the memory |
| mw_di | input | 1 | Serial data from the memory |

## Verification
Two events can fall in the same cycle: the done strobe that ends one read, and the acceptance of the next request. To provoke this, the bench holds the request line high across a whole read and changes the address partway through. It judges the outcome on three points. The first word must belong to the first address, since the mid-frame change must be ignored. In the done cycle, busy must read low. In the very next cycle a second frame must open, carrying the second address and delivering its word.

// File: rtl/mwr_pkg.sv
package mwr_pkg;

    localparam int          LEAD_W   = 4;
    localparam logic [3:0]  LEAD_IN  = 4'b0110;
    localparam int          WADDR_W  = 6;
    localparam int          WORD_W   = 16;
    localparam int          TX_BITS  = LEAD_W + WADDR_W;
    localparam int          CNT_W    = $clog2((TX_BITS > WORD_W) ? TX_BITS : WORD_W);

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_TX_LO,
        PH_TX_HI,
        PH_RX_LO,
        PH_RX_HI,
        PH_HOLD
    } phase_e;

    typedef struct packed {
        logic cs;
        logic sk;
        logic dout;
    } mw_pins_t;

    function automatic logic [WORD_W-1:0] swap_bytes(input logic [WORD_W-1:0] w);
        return {w[7:0], w[15:8]};
    endfunction

endpackage

// File: rtl/mwr_half_timer.sv
module mwr_half_timer #(
    parameter int HALF_PER = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int            CW   = (HALF_PER > 1) ? $clog2(HALF_PER) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_PER - 1);

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) cnt <= '0;
        else                     cnt <= cnt + 1'b1;
    end

    generate
        if (HALF_PER > 1) begin : g_spacing
            AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);  // R10
        end
    endgenerate

    AST_CNT_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !$past(run) |-> (cnt == '0));  // R10

endmodule

// File: rtl/mwr_seq.sv
module mwr_seq
    import mwr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic               start,
    input  logic [WADDR_W-1:0] start_addr,
    input  logic               din,
    output phase_e             phase,
    output logic               tx_msb,
    output logic               done,
    output logic [WORD_W-1:0]  rd_word
);
    localparam logic [CNT_W-1:0] TX_LAST = CNT_W'(TX_BITS - 1);
    localparam logic [CNT_W-1:0] RX_LAST = CNT_W'(WORD_W - 1);

    logic [TX_BITS-1:0] tx_sreg;
    logic [WORD_W-1:0]  rx_sreg;
    logic [CNT_W-1:0]   bit_cnt;

    assign tx_msb = tx_sreg[TX_BITS-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            tx_sreg <= '0;
            rx_sreg <= '0;
            bit_cnt <= '0;
            done    <= 1'b0;
            rd_word <= '0;
        end else begin
            done <= 1'b0;
            case (phase)
                PH_IDLE: if (start) begin
                    phase   <= PH_SETUP;
                    tx_sreg <= {LEAD_IN, start_addr};
                    bit_cnt <= '0;
                end
                PH_SETUP: if (tick) phase <= PH_TX_LO;
                PH_TX_LO: if (tick) phase <= PH_TX_HI;
                PH_TX_HI: if (tick) begin
                    if (bit_cnt == TX_LAST) begin
                        phase   <= PH_RX_LO;
                        bit_cnt <= '0;
                    end else begin
                        phase   <= PH_TX_LO;
                        tx_sreg <= {tx_sreg[TX_BITS-2:0], 1'b0};
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                PH_RX_LO: if (tick) phase <= PH_RX_HI;
                PH_RX_HI: if (tick) begin
                    rx_sreg <= {rx_sreg[WORD_W-2:0], din};
                    if (bit_cnt == RX_LAST) begin
                        phase <= PH_HOLD;
                    end else begin
                        phase   <= PH_RX_LO;
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                PH_HOLD: if (tick) begin
                    phase   <= PH_IDLE;
                    done    <= 1'b1;
                    rd_word <= swap_bytes(rx_sreg);
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);  // R8
    AST_WORD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(rd_word));  // R8
    AST_DONE_FROM_HOLD: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(phase) == PH_HOLD));  // R7

endmodule

// File: rtl/mwr_pin_drive.sv
module mwr_pin_drive
    import mwr_pkg::*;
(
    input  phase_e   phase,
    input  logic     tx_msb,
    output mw_pins_t pins
);
    always_comb begin
        pins = '0;
        case (phase)
            PH_SETUP, PH_RX_LO, PH_HOLD: pins.cs = 1'b1;
            PH_TX_LO: begin
                pins.cs   = 1'b1;
                pins.dout = tx_msb;
            end
            PH_TX_HI: begin
                pins.cs   = 1'b1;
                pins.sk   = 1'b1;
                pins.dout = tx_msb;
            end
            PH_RX_HI: begin
                pins.cs = 1'b1;
                pins.sk = 1'b1;
            end
            default: pins = '0;
        endcase
    end
endmodule

// File: rtl/mw_eeprom_reader.sv
module mw_eeprom_reader
    import mwr_pkg::*;
#(
    parameter int HALF_PER   = 4,
    parameter int REQ_ADDR_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic [REQ_ADDR_W-1:0] req_addr,
    output logic                  busy,
    output logic                  done,
    output logic [WORD_W-1:0]     rd_word,
    output logic                  mw_cs,
    output logic                  mw_sk,
    output logic                  mw_do,
    input  logic                  mw_di
);
    phase_e   phase;
    logic     tick;
    logic     tx_msb;
    logic     start;
    mw_pins_t pins;

    assign busy  = (phase != PH_IDLE);
    assign start = req_valid && !busy;

    mwr_half_timer #(.HALF_PER(HALF_PER)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (busy),
        .tick (tick)
    );

    mwr_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .start      (start),
        .start_addr (req_addr[WADDR_W-1:0]),
        .din        (mw_di),
        .phase      (phase),
        .tx_msb     (tx_msb),
        .done       (done),
        .rd_word    (rd_word)
    );

    mwr_pin_drive u_pins (
        .phase  (phase),
        .tx_msb (tx_msb),
        .pins   (pins)
    );

    assign mw_cs = pins.cs;
    assign mw_sk = pins.sk;
    assign mw_do = pins.dout;

    AST_SK_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
        mw_sk |-> mw_cs);  // R6
    AST_CS_RISE_SK_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(mw_cs) |-> !mw_sk);  // R1
    AST_CS_FALL_SK_LOW: assert property (@(posedge clk) disable iff (rst)
        $fell(mw_cs) |-> !$past(mw_sk));  // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mw_cs && !mw_sk && !mw_do));  // R7
    AST_DO_STABLE_HI: assert property (@(posedge clk) disable iff (rst)
        (mw_sk && $past(mw_sk)) |-> $stable(mw_do));  // R4
    AST_BUSY_END_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);  // R9

endmodule

// File: tb/tb_mw_eeprom_reader.sv
module tb_mw_eeprom_reader;
    localparam int CLK_PERIOD = 10;
    localparam int HP         = 3;
    localparam int FRAME_CYC  = 54 * HP + 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [7:0]  req_addr = '0;
    logic        busy, done, mw_cs, mw_sk, mw_do;
    logic        mw_di = 1'b0;
    logic [15:0] rd_word;

    int nchk = 0, nfail = 0;
    bit finished = 0;

    mw_eeprom_reader #(.HALF_PER(HP), .REQ_ADDR_W(8)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .busy(busy), .done(done), .rd_word(rd_word),
        .mw_cs(mw_cs), .mw_sk(mw_sk), .mw_do(mw_do), .mw_di(mw_di)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] mem_word(input int a);
        logic [15:0] m;
        m = 16'(a * 4951);
        return m ^ 16'hA5C3;
    endfunction

    function automatic logic [15:0] swp(input logic [15:0] w);
        return {w[7:0], w[15:8]};
    endfunction

    // memory model and line monitor, sampled at negedge
    logic        prev_cs = 0, prev_sk = 0, prev_do = 0;
    int          rise_cnt = 0, hi_len = 0, hp_bad = 0, proto_bad = 0, frames = 0;
    logic [9:0]  cmd = '0;
    logic [15:0] cur_word = '0;

    always @(negedge clk) begin
        if (rst) begin
            prev_cs = 0; prev_sk = 0; prev_do = 0; mw_di = 0;
        end else begin
            if (mw_cs && !prev_cs) begin
                frames++; rise_cnt = 0; cmd = '0;
                if (mw_sk) proto_bad++;
            end
            if (!mw_cs && prev_cs && prev_sk) proto_bad++;
            if (mw_sk && !mw_cs) proto_bad++;
            if (mw_sk && prev_sk && (mw_do != prev_do)) proto_bad++;
            if (mw_sk && !prev_sk) begin
                if (rise_cnt < 10) cmd = {cmd[8:0], mw_do};
                rise_cnt++;
                hi_len = 1;
            end else if (mw_sk) begin
                hi_len++;
            end
            if (!mw_sk && prev_sk) begin
                if (hi_len != HP) hp_bad++;
                if (rise_cnt == 10) cur_word = mem_word(int'(cmd[5:0]));
                if (rise_cnt >= 10 && rise_cnt < 26) mw_di = cur_word[25 - rise_cnt];
                else mw_di = 1'b0;
            end
            if (!mw_cs) mw_di = 1'b0;
            prev_cs = mw_cs; prev_sk = mw_sk; prev_do = mw_do;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk); #1;
    endtask

    // waits for done; returns cycles counted from the drive edge
    task automatic wait_done(output int n);
        n = 0;
        do begin
            step(); n++;
        end while (!done && n < 3000);
        if (!done) begin
            nfail++; nchk++;
            $display("FAIL R9 actual=timeout expected=done");
        end
    endtask

    task automatic read_one(input logic [7:0] a, input string tag);
        int n, f0, pb0, hb0;
        f0 = frames; pb0 = proto_bad; hb0 = hp_bad;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        step();
        req_valid = 1'b0; req_addr = ~a;
        chk({tag, " R9 busy after accept"}, busy, 1);
        chk({tag, " R1 cs high sk low at start"}, {mw_cs, mw_sk}, 2'b10);
        wait_done(n);
        n = n + 1;
        chk({tag, " R10 frame length"}, n, FRAME_CYC);
        chk({tag, " R9 busy low in done cycle"}, busy, 0);
        chk({tag, " R2 R3 command bits"}, cmd, {4'b0110, a[5:0]});
        chk({tag, " R5 rising edges"}, rise_cnt, 26);
        chk({tag, " R8 swapped word"}, rd_word, swp(mem_word(int'(a[5:0]))));
        chk({tag, " R10 half periods"}, hp_bad - hb0, 0);
        chk({tag, " R4 R6 R7 line protocol"}, proto_bad - pb0, 0);
        chk({tag, " R9 one frame"}, frames - f0, 1);
        step();
        chk({tag, " R8 done one cycle"}, done, 0);
        chk({tag, " R8 word held"}, rd_word, swp(mem_word(int'(a[5:0]))));
        chk({tag, " R7 lines idle"}, {mw_cs, mw_sk, mw_do}, 3'b000);
    endtask

    task automatic t_reset();
        step();
        chk("R7 reset lines", {mw_cs, mw_sk, mw_do}, 3'b000);
        chk("R8 reset done/word", {done, rd_word}, 17'h0);
        chk("R9 reset busy", busy, 0);
    endtask

    task automatic t_patterns();
        read_one(8'h00, "addr0");
        read_one(8'h3F, "addr63");
        read_one(8'h2A, "addr2A");
        read_one(8'h15, "addr15");
    endtask

    task automatic t_high_bits_ignored();
        read_one(8'hC5, "R3 upper bits");
    endtask

    task automatic t_busy_ignore();
        int n, f0;
        f0 = frames;
        @(negedge clk);
        req_valid = 1'b1; req_addr = 8'h11;
        step();
        req_valid = 1'b0;
        repeat (20 * HP) step();
        req_valid = 1'b1; req_addr = 8'h22;
        step();
        req_valid = 1'b0;
        wait_done(n);
        chk("R9 busy request ignored: addr", cmd, {4'b0110, 6'h11});
        chk("R9 busy request ignored: word", rd_word, swp(mem_word(6'h11)));
        repeat (5) step();
        chk("R9 busy request ignored: frames", frames - f0, 1);
        chk("R9 busy request ignored: idle", busy, 0);
    endtask

    task automatic t_back_to_back();
        int n;
        @(negedge clk);
        req_valid = 1'b1; req_addr = 8'h07;
        step();
        req_addr = 8'h38;
        wait_done(n);
        chk("R9 b2b first word", rd_word, swp(mem_word(6'h07)));
        chk("R9 b2b busy low at done", busy, 0);
        step();
        req_valid = 1'b0;
        chk("R9 b2b second accepted", busy, 1);
        chk("R1 b2b second start", {mw_cs, mw_sk}, 2'b10);
        wait_done(n);
        chk("R3 b2b second addr", cmd, {4'b0110, 6'h38});
        chk("R8 b2b second word", rd_word, swp(mem_word(6'h38)));
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_patterns();
        t_high_bits_ignored();
        t_busy_ignore();
        t_back_to_back();
        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 150000);
        nchk++; nfail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

endmodule